// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Used-Bit Tracking

This block is a small fully associative address translation cache. Each entry maps one naturally aligned virtual page to a page-table payload. The entry is qualified by a partition number, a context number and a flag that marks the mapping as a real (context-free) one. Any entry can be locked, and a locked entry is never chosen as an automatic victim. Lookups compare the request against every entry in one cycle and return a registered result. Maintenance commands arrive over a valid/ready channel and are applied at the following clock edge. The commands are: insert (at a given slot or at an automatically chosen one), remove one page, remove one context, remove everything unlocked in a partition, and flush.

Each entry carries a used flag. An insert sets it, and so does every lookup that hits, unless the lookup is marked as a probe. When the flags would otherwise all be set at once, the flags of unlocked entries are cleared as a group. A diagnostic port reads any entry's tag word, payload and used flag combinationally.

Top module: `tlb_nru`

## Requirements
- R1: A lookup hits an entry when all of the following hold: the entry is valid, `lk_va` masked to the entry's page size equals the entry's page base, the partitions are equal, the real flags are equal, and either the request is real or the contexts are equal. Page size code s in 0..3 means a page of 2^(13+3s) bytes. If several entries match, the lowest index is reported. On a miss `lk_hit`, `lk_idx` and `lk_data` are zero.
- R2: Before an insert is written, every valid entry is invalidated when it overlaps the new page and also has the same real flag, the same partition, and (for a non-real mapping) the same context.
- R3: An automatic insert (`cmd_auto`=1) takes the lowest-index invalid entry, counted after the conflict removal of R2.
- R4: If no entry is free, the automatic insert scans from the entry after the last round-robin victim, wraps around, skips locked entries and stops before coming back to that victim. If the scan finds nothing, it overwrites entry ENTRIES-1. Only a victim found by this scan updates the last-victim pointer, which is zero after reset.
- R5: An indexed insert (`cmd_auto`=0) writes entry `cmd_idx` directly, even when that entry is locked.
- R6: An insert sets the used flag of the written entry. A lookup hit with `lk_probe`=0 sets the used flag of the hit entry. A hit with `lk_probe`=1 leaves all used flags unchanged.
- R7: If setting a used flag would leave every entry used, all used flags of unlocked entries are cleared and only the entry just touched is set again.
- R8: Demap page (op 1) invalidates every entry that the given VA, partition, context and real flag would hit under R1.
- R9: Demap context (op 2) invalidates every valid entry whose partition and context both match, whether or not it is locked.
- R10: Demap partition (op 3) invalidates valid entries of the given partition only when they are unlocked.
- R11: Flush (op 4) invalidates every entry and clears every used flag.
- R12: The diagnostic tag of a valid entry has the partition in bits 63:61, the real flag in bit 60, zero in bits 59:58, the inverted size code in bits 57:56, and the page base ORed with the context in bits 55:0. The payload is returned on `dg_data`. An invalid entry reads all ones on both `dg_tag` and `dg_data`, and `dg_used` shows the entry's used flag.
- R13: After reset all entries are invalid. `cmd_ready` is low exactly while `lk_valid` is high. An accepted command (op 0 insert, ops 1 to 4 as above) takes effect at the next clock edge. Ops 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | VA_W | Lookup virtual address |
| lk_part | input | PART_W | Lookup partition |
| lk_ctx | input | CTX_W | Lookup context |
| lk_real | input | 1 | Lookup is a real-address request |
| lk_probe | input | 1 | Lookup must not update used flags |
| lk_done | output | 1 | Registered: a lookup was made last cycle |
| lk_hit | output | 1 | Registered hit |
| lk_idx | output | IW | Registered index of the hit entry |
| lk_data | output | DATA_W | Registered payload of the hit entry |
| cmd_valid | input | 1 | Maintenance command offered |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_op | input | 3 | Command code (see R13) |
| cmd_va | input | VA_W | Command virtual address |
| cmd_part | input | PART_W | Command partition |
| cmd_ctx | input | CTX_W | Command context |
| cmd_real | input | 1 | Command real flag |
| cmd_size | input | 2 | Page size code for insert |
| cmd_lock | input | 1 | Lock flag for insert |
| cmd_data | input | DATA_W | Payload for insert |
| cmd_idx | input | IW | Target entry for indexed insert |
| cmd_auto | input | 1 | Insert chooses its own victim |
| dg_idx | input | IW | Entry selected for diagnostic read |
| dg_tag | output | 64 | Diagnostic tag word |
| dg_data | output | DATA_W | Diagnostic payload |
| dg_used | output | 1 | Diagnostic used flag |

## Verification
A lookup presented in one cycle has its hit, index and payload due one clock edge later. The bench therefore drives `lk_valid` on a falling edge and samples the outputs on the next falling edge. A command applies at the rising edge inside its one-cycle window. Its result is read on the combinational diagnostic port half a cycle later, after `dg_idx` has settled. `cmd_ready` is combinational and is checked in the same cycle as `lk_valid`.

// File: rtl/tlb_nru.sv
module tlb_nru #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 40,
  parameter int PART_W  = 3,
  parameter int CTX_W   = 13,
  parameter int DATA_W  = 32,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [PART_W-1:0] lk_part,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic              lk_real,
  input  logic              lk_probe,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [IW-1:0]     lk_idx,
  output logic [DATA_W-1:0] lk_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [PART_W-1:0] cmd_part,
  input  logic [CTX_W-1:0]  cmd_ctx,
  input  logic              cmd_real,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_lock,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [IW-1:0]     cmd_idx,
  input  logic              cmd_auto,
  input  logic [IW-1:0]     dg_idx,
  output logic [63:0]       dg_tag,
  output logic [DATA_W-1:0] dg_data,
  output logic              dg_used
);

  localparam logic [2:0] OP_INS  = 3'd0;
  localparam logic [2:0] OP_DPG  = 3'd1;
  localparam logic [2:0] OP_DCTX = 3'd2;
  localparam logic [2:0] OP_DALL = 3'd3;
  localparam logic [2:0] OP_FLSH = 3'd4;

  logic [ENTRIES-1:0] vld, used, lock, rflag;
  logic [VA_W-1:0]    base [ENTRIES];
  logic [1:0]         szc  [ENTRIES];
  logic [PART_W-1:0]  part [ENTRIES];
  logic [CTX_W-1:0]   ctx  [ENTRIES];
  logic [DATA_W-1:0]  dat  [ENTRIES];
  logic [IW-1:0]      last_rep;

  function automatic logic [VA_W-1:0] pmask(input logic [1:0] s);
    return {VA_W{1'b1}} << (13 + 3 * int'(s));
  endfunction

  function automatic logic [ENTRIES-1:0] touch(input logic [ENTRIES-1:0] u,
                                               input logic [ENTRIES-1:0] lk,
                                               input logic [IW-1:0] idx);
    logic [ENTRIES-1:0] oh, n;
    oh = '0;
    oh[idx] = 1'b1;
    n = u | oh;
    if (&n) n = (n & lk) | oh;
    return n;
  endfunction

  assign cmd_ready = !lk_valid;
  wire cmd_fire = cmd_valid && cmd_ready;
  wire ins_fire = cmd_fire && (cmd_op == OP_INS);

  logic [ENTRIES-1:0] lk_match, pg_match, conflict, ctx_sel, part_sel, left;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i] = vld[i] && part[i] == lk_part && rflag[i] == lk_real &&
                    (lk_real || ctx[i] == lk_ctx) &&
                    ((lk_va & pmask(szc[i])) == base[i]);
      pg_match[i] = vld[i] && part[i] == cmd_part && rflag[i] == cmd_real &&
                    (cmd_real || ctx[i] == cmd_ctx) &&
                    ((cmd_va & pmask(szc[i])) == base[i]);
      conflict[i] = vld[i] && part[i] == cmd_part && rflag[i] == cmd_real &&
                    (cmd_real || ctx[i] == cmd_ctx) &&
                    (((base[i] ^ cmd_va) &
                      pmask((szc[i] > cmd_size) ? szc[i] : cmd_size)) == '0);
      ctx_sel[i]  = vld[i] && part[i] == cmd_part && ctx[i] == cmd_ctx;
      part_sel[i] = vld[i] && part[i] == cmd_part && !lock[i];
    end
  end

  assign left = vld & ~conflict;

  logic          hit;
  logic [IW-1:0] hidx;
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lk_match[i]) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
  end

  logic          have_free, rr_found;
  logic [IW-1:0] free_idx, rr_idx, tgt;
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!left[i]) begin
        have_free = 1'b1;
        free_idx  = IW'(i);
      end
    rr_found = 1'b0;
    rr_idx   = IW'(ENTRIES - 1);
    for (int k = ENTRIES - 1; k >= 1; k--)
      if (!lock[(int'(last_rep) + k) % ENTRIES]) begin
        rr_found = 1'b1;
        rr_idx   = IW'((int'(last_rep) + k) % ENTRIES);
      end
  end

  assign tgt = !cmd_auto ? cmd_idx : (have_free ? free_idx : rr_idx);
  wire upd_last = cmd_auto && !have_free && rr_found;

  logic [ENTRIES-1:0] vld_n, used_n, lock_n, kill, oh_t;
  always_comb begin
    vld_n  = vld;
    used_n = used;
    lock_n = lock;
    kill   = '0;
    oh_t   = '0;
    oh_t[tgt] = 1'b1;
    if (lk_valid) begin
      if (hit && !lk_probe) used_n = touch(used, lock, hidx);
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_INS: begin
          vld_n  = left | oh_t;
          lock_n = (lock & ~conflict & ~oh_t) | (cmd_lock ? oh_t : '0);
          used_n = touch(used & ~conflict, lock_n, tgt);
        end
        OP_DPG:  kill = pg_match;
        OP_DCTX: kill = ctx_sel;
        OP_DALL: kill = part_sel;
        OP_FLSH: kill = '1;
        default: ;
      endcase
    end
    vld_n  = vld_n & ~kill;
    used_n = used_n & ~kill;
    lock_n = lock_n & ~kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld      <= '0;
      used     <= '0;
      lock     <= '0;
      last_rep <= '0;
      lk_done  <= 1'b0;
      lk_hit   <= 1'b0;
      lk_idx   <= '0;
      lk_data  <= '0;
    end else begin
      vld     <= vld_n;
      used    <= used_n;
      lock    <= lock_n;
      lk_done <= lk_valid;
      lk_hit  <= lk_valid && hit;
      lk_idx  <= (lk_valid && hit) ? hidx : '0;
      lk_data <= (lk_valid && hit) ? dat[hidx] : '0;
      if (ins_fire && upd_last) last_rep <= tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      base[tgt]  <= cmd_va & pmask(cmd_size);
      szc[tgt]   <= cmd_size;
      part[tgt]  <= cmd_part;
      ctx[tgt]   <= cmd_ctx;
      rflag[tgt] <= cmd_real;
      dat[tgt]   <= cmd_data;
    end
  end

  wire dg_ok = (int'(dg_idx) < ENTRIES) && vld[dg_idx];
  assign dg_tag  = dg_ok ? {3'(part[dg_idx]), rflag[dg_idx], 2'b00, ~szc[dg_idx],
                            56'(base[dg_idx]) | 56'(ctx[dg_idx])} : '1;
  assign dg_data = dg_ok ? dat[dg_idx] : '1;
  assign dg_used = (int'(dg_idx) < ENTRIES) && used[dg_idx];

  // R6
  hit_marks_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_hit && !$past(lk_probe)) |-> used[lk_idx]);
  // R1
  hit_entry_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_hit) |-> vld[lk_idx]);
  // R6
  used_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used & ~vld) == '0);
  // R10
  dall_spares_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_fire && cmd_op == OP_DALL) |-> (($past(vld & lock) & ~vld) == '0));
  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_fire && cmd_op == OP_FLSH) |-> (vld == '0 && used == '0));
  // R5
  indexed_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ins_fire && !cmd_auto) |-> vld[$past(cmd_idx)]);

endmodule

// File: tb/tlb_nru_test.sv
module tlb_nru_test;
  localparam int N = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic lk_valid, lk_real, lk_probe, lk_done, lk_hit;
  logic [31:0] lk_va;
  logic [2:0]  lk_part;
  logic [12:0] lk_ctx;
  logic [1:0]  lk_idx;
  logic [15:0] lk_data;
  logic cmd_valid, cmd_ready, cmd_real, cmd_lock, cmd_auto;
  logic [2:0]  cmd_op, cmd_part;
  logic [31:0] cmd_va;
  logic [12:0] cmd_ctx;
  logic [1:0]  cmd_size, cmd_idx, dg_idx;
  logic [15:0] cmd_data, dg_data;
  logic [63:0] dg_tag;
  logic dg_used;

  tlb_nru #(.ENTRIES(N), .VA_W(32), .PART_W(3), .CTX_W(13), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_part(lk_part), .lk_ctx(lk_ctx),
    .lk_real(lk_real), .lk_probe(lk_probe), .lk_done(lk_done), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_data(lk_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_va(cmd_va),
    .cmd_part(cmd_part), .cmd_ctx(cmd_ctx), .cmd_real(cmd_real), .cmd_size(cmd_size),
    .cmd_lock(cmd_lock), .cmd_data(cmd_data), .cmd_idx(cmd_idx), .cmd_auto(cmd_auto),
    .dg_idx(dg_idx), .dg_tag(dg_tag), .dg_data(dg_data), .dg_used(dg_used));

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [31:0] va;
    logic [2:0]  pt;
    logic [12:0] cx;
    logic        rl;
    logic        hit;
    logic [1:0]  idx;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h0001_0ABC, 3'd1, 13'd5, 1'b0, 1'b1, 2'd0, 16'hA001},
    '{32'h0002_FFF0, 3'd1, 13'd5, 1'b0, 1'b1, 2'd1, 16'hA002},
    '{32'h0003_0000, 3'd1, 13'd5, 1'b0, 1'b0, 2'd0, 16'h0000},
    '{32'h0001_0000, 3'd1, 13'd6, 1'b0, 1'b0, 2'd0, 16'h0000},
    '{32'h0001_0000, 3'd2, 13'd5, 1'b0, 1'b1, 2'd3, 16'hA004},
    '{32'h007F_FFFC, 3'd1, 13'd9, 1'b1, 1'b1, 2'd2, 16'hA003},
    '{32'h0001_0000, 3'd1, 13'd5, 1'b1, 1'b0, 2'd0, 16'h0000},
    '{32'h0080_0000, 3'd1, 13'd0, 1'b1, 1'b0, 2'd0, 16'h0000}
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [31:0] va, input logic [2:0] pt,
                     input logic [12:0] cx, input logic rl, input logic [1:0] sz,
                     input logic lk, input logic [15:0] d, input logic [1:0] idx,
                     input logic au);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_part = pt; cmd_ctx = cx;
    cmd_real = rl; cmd_size = sz; cmd_lock = lk; cmd_data = d; cmd_idx = idx;
    cmd_auto = au;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [2:0] pt, input logic [12:0] cx,
                      input logic rl, input logic pr,
                      output logic h, output logic [1:0] i, output logic [15:0] d);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_part = pt; lk_ctx = cx; lk_real = rl; lk_probe = pr;
    @(negedge clk);
    lk_valid = 1'b0;
    h = lk_hit; i = lk_idx; d = lk_data;
  endtask

  task automatic dg(input int i, output logic [63:0] t, output logic [15:0] d,
                    output logic u);
    dg_idx = 2'(i);
    #1;
    t = dg_tag; d = dg_data; u = dg_used;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic h, u;
    logic [1:0] ix;
    logic [15:0] d;
    logic [63:0] t;
    rst_n = 1'b0; lk_valid = 0; lk_va = 0; lk_part = 0; lk_ctx = 0; lk_real = 0;
    lk_probe = 0; cmd_valid = 0; cmd_op = 0; cmd_va = 0; cmd_part = 0; cmd_ctx = 0;
    cmd_real = 0; cmd_size = 0; cmd_lock = 0; cmd_data = 0; cmd_idx = 0; cmd_auto = 0;
    dg_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 reset lk_done", 64'(lk_done), 64'd0);
    chk("R13 reset cmd_ready", 64'(cmd_ready), 64'd1);
    for (int e = 0; e < N; e++) begin
      dg(e, t, d, u);
      chk("R12 reset tag ones", t, '1);
      chk("R12 reset data ones", 64'(d), 64'hFFFF);
    end

    // R3 fill free entries in order
    cmd(3'd0, 32'h0001_0000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 16'hA001, 2'd0, 1'b1);
    cmd(3'd0, 32'h0002_0000, 3'd1, 13'd5, 1'b0, 2'd1, 1'b0, 16'hA002, 2'd0, 1'b1);
    cmd(3'd0, 32'h0040_0000, 3'd1, 13'd0, 1'b1, 2'd3, 1'b0, 16'hA003, 2'd0, 1'b1);
    cmd(3'd0, 32'h0001_0000, 3'd2, 13'd5, 1'b0, 2'd0, 1'b0, 16'hA004, 2'd0, 1'b1);
    dg(3, t, d, u);
    chk("R3 fourth insert to entry3", 64'(d), 64'hA004);
    dg(0, t, d, u);
    chk("R12 tag entry0", t, 64'h2300_0000_0001_0005);
    dg(2, t, d, u);
    chk("R12 tag entry2 real", t, 64'h3000_0000_0040_0000);
    // R7 fourth insert reset the group: only entry3 used
    dg(0, t, d, u); chk("R7 entry0 cleared", 64'(u), 64'd0);
    dg(3, t, d, u); chk("R7 entry3 used", 64'(u), 64'd1);

    for (int v = 0; v < NV; v++) begin
      look(VEC[v].va, VEC[v].pt, VEC[v].cx, VEC[v].rl, 1'b1, h, ix, d);
      chk($sformatf("R1 vec%0d hit", v), 64'(h), 64'(VEC[v].hit));
      chk($sformatf("R1 vec%0d idx", v), 64'(ix), 64'(VEC[v].idx));
      chk($sformatf("R1 vec%0d data", v), 64'(d), 64'(VEC[v].data));
    end

    // R6 probe does not touch used, normal hit does
    look(32'h0001_0000, 3'd1, 13'd5, 1'b0, 1'b0, h, ix, d);
    dg(0, t, d, u); chk("R6 hit sets used", 64'(u), 64'd1);
    look(32'h0002_0000, 3'd1, 13'd5, 1'b0, 1'b1, h, ix, d);
    dg(1, t, d, u); chk("R6 probe leaves used", 64'(u), 64'd0);
    look(32'h0002_0000, 3'd1, 13'd5, 1'b0, 1'b0, h, ix, d);
    // R13 cmd_ready low during lookup
    @(negedge clk); lk_valid = 1'b1; #1;
    chk("R13 ready low with lookup", 64'(cmd_ready), 64'd0);
    lk_valid = 1'b0;
    look(32'h0040_0000, 3'd1, 13'd0, 1'b1, 1'b0, h, ix, d);
    dg(0, t, d, u); chk("R7 group reset entry0", 64'(u), 64'd0);
    dg(1, t, d, u); chk("R7 group reset entry1", 64'(u), 64'd0);
    dg(2, t, d, u); chk("R7 touched entry2 kept", 64'(u), 64'd1);

    // R4 round robin from last victim (0) -> entry1
    cmd(3'd0, 32'h0100_0000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 16'hB001, 2'd0, 1'b1);
    dg(1, t, d, u);
    chk("R4 rr victim entry1", 64'(d), 64'hB001);
    chk("R6 insert sets used", 64'(u), 64'd1);
    // R5 indexed locked insert into entry2
    cmd(3'd0, 32'h0200_0000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b1, 16'hB002, 2'd2, 1'b0);
    dg(2, t, d, u);
    chk("R5 indexed insert entry2", 64'(d), 64'hB002);
    // R4 skip locked entry2 -> entry3
    cmd(3'd0, 32'h0300_0000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 16'hB003, 2'd0, 1'b1);
    dg(3, t, d, u); chk("R4 skip locked to entry3", 64'(d), 64'hB003);
    dg(2, t, d, u); chk("R4 locked entry2 intact", 64'(d), 64'hB002);

    // R13 unknown op ignored
    cmd(3'd7, 32'h0, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 16'h0, 2'd0, 1'b0);
    dg(3, t, d, u); chk("R13 op7 ignored", 64'(d), 64'hB003);

    // R10 demap partition 1 spares locked
    cmd(3'd3, 32'h0, 3'd1, 13'd0, 1'b0, 2'd0, 1'b0, 16'h0, 2'd0, 1'b0);
    dg(0, t, d, u); chk("R10 entry0 removed", t, '1);
    dg(1, t, d, u); chk("R10 entry1 removed", t, '1);
    dg(3, t, d, u); chk("R10 entry3 removed", t, '1);
    look(32'h0200_0000, 3'd1, 13'd5, 1'b0, 1'b0, h, ix, d);
    chk("R10 locked entry still hits", 64'(d), 64'hB002);

    // R2 conflict removal
    cmd(3'd0, 32'h0400_0000, 3'd1, 13'd7, 1'b0, 2'd0, 1'b0, 16'hB004, 2'd0, 1'b1);
    cmd(3'd0, 32'h0400_2000, 3'd1, 13'd7, 1'b0, 2'd0, 1'b0, 16'hB006, 2'd0, 1'b1);
    cmd(3'd0, 32'h0400_0000, 3'd1, 13'd8, 1'b0, 2'd0, 1'b0, 16'hB007, 2'd0, 1'b1);
    dg(1, t, d, u); chk("R3 lowest free entry1", 64'(d), 64'hB006);
    cmd(3'd0, 32'h0400_0000, 3'd1, 13'd7, 1'b0, 2'd2, 1'b0, 16'hB008, 2'd0, 1'b1);
    dg(0, t, d, u); chk("R2 new page in entry0", 64'(d), 64'hB008);
    dg(1, t, d, u); chk("R2 overlapped entry1 removed", t, '1);
    dg(3, t, d, u); chk("R2 other context kept", 64'(d), 64'hB007);
    look(32'h0406_0000, 3'd1, 13'd7, 1'b0, 1'b0, h, ix, d);
    chk("R2 large page hits", 64'(d), 64'hB008);

    // R8 demap page ctx 8
    cmd(3'd1, 32'h0400_0000, 3'd1, 13'd8, 1'b0, 2'd0, 1'b0, 16'h0, 2'd0, 1'b0);
    dg(3, t, d, u); chk("R8 page removed", t, '1);
    dg(0, t, d, u); chk("R8 other ctx kept", 64'(d), 64'hB008);
    // R9 demap context 5 removes locked entry2
    cmd(3'd2, 32'h0, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 16'h0, 2'd0, 1'b0);
    dg(2, t, d, u); chk("R9 locked ctx entry removed", t, '1);
    dg(0, t, d, u); chk("R9 ctx7 kept", 64'(d), 64'hB008);

    // R11 flush
    cmd(3'd4, 32'h0, 3'd0, 13'd0, 1'b0, 2'd0, 1'b0, 16'h0, 2'd0, 1'b0);
    for (int e = 0; e < N; e++) begin
      dg(e, t, d, u);
      chk("R11 flush invalid", t, '1);
      chk("R11 flush used clear", 64'(u), 64'd0);
    end

    // R4 all locked -> last entry
    for (int e = 0; e < N; e++)
      cmd(3'd0, 32'h1000_0000 + 32'(e) * 32'h2000, 3'd1, 13'd1, 1'b0, 2'd0, 1'b1,
          16'hC000 + 16'(e), 2'(e), 1'b0);
    cmd(3'd0, 32'h2000_0000, 3'd1, 13'd1, 1'b0, 2'd0, 1'b0, 16'hC0FF, 2'd0, 1'b1);
    dg(3, t, d, u); chk("R4 all locked overwrites entry3", 64'(d), 64'hC0FF);
    for (int e = 0; e < N - 1; e++) begin
      dg(e, t, d, u);
      chk("R4 locked entries intact", 64'(d), 64'hC000 + 64'(e));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule